// File: doc/BRIEF.md
# SPI Programming-Mode Entry Sequencer

This block brings an attached microcontroller into its serial programming mode over a four-wire SPI link. On a start strobe it pulls the target's combined reset/select line low while keeping the serial clock low. It then waits a long settle interval, measured in system clock cycles, before the first clock edge.

After the wait it shifts out a fixed four-byte enable command, `AC 53 00 00`, at a slow serial rate. It uses SPI mode 0, most significant bit first. While the third command byte is on the wire, the target should return `53`. The block captures that returned byte, releases the select line half a serial period after the last falling clock edge, and reports the outcome. It pulses done when the echo matched. It raises an error flag when the echo did not match, and that flag stays up until the next accepted start.

The settle time and the serial clock divider are derived from three parameters: `SYS_CLK_HZ`, `SCK_HZ` and `HOLD_US`. The half period is `HALF_DIV = SYS_CLK_HZ / (2*SCK_HZ)` cycles, and the hold is `HOLD_CYC = (SYS_CLK_HZ/1000)*HOLD_US/1000` cycles. A start strobe is sampled on the rising system clock edge.

Top module: `spi_prog_entry`

## Requirements
- R1: While idle, `ss_n` is high and `sclk` is low; `sclk` is low in the cycle `ss_n` falls and stays low during the hold.
- R2: `ss_n` goes low in the cycle after a start is sampled in idle, and stays low for `HOLD_CYC` cycles plus one low half period before `sclk` first rises.
- R3: During the frame `sclk` gives exactly 32 pulses, each `HALF_DIV` cycles low followed by `HALF_DIV` cycles high.
- R4: `mosi` carries `0xAC530000` most significant bit first. Bit 31 is valid from the cycle `ss_n` falls. Each next bit appears together with a falling `sclk`, and `mosi` never changes while `sclk` is high. `mosi` is 0 when no frame is active.
- R5: `miso` is sampled on each rising `sclk` edge. The eight bits sampled during pulses 17 to 24 (the third byte, first received bit most significant) are compared with `0x53`.
- R6: `HALF_DIV` cycles after the last falling `sclk` edge, `ss_n` returns high and `busy` falls in the same cycle.
- R7: On an echo match, `done` is high for exactly the one cycle in which `ss_n` returns high.
- R8: On an echo mismatch, `err` rises in the release cycle and stays high until the next accepted start clears it; `done` stays low.
- R9: A start that is sampled while `busy` is high, including on the final edge of the frame, has no effect on any output.
- R10: During reset, `ss_n` is high and `sclk`, `mosi`, `busy`, `done` and `err` are low.
- R11: `busy` is high from the cycle after an accepted start through the last cycle before release, and `ss_n` is low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the entry sequence, sampled on the rising edge |
| sclk | output | 1 | Serial clock to the target, idles low |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| ss_n | output | 1 | Active-low reset/select line of the target |
| busy | output | 1 | High while a sequence is in progress |
| done | output | 1 | One-cycle pulse on a matched echo |
| err | output | 1 | Echo mismatch flag, held until the next accepted start |

## Verification
The completion of one sequence and the acceptance of the next can land on neighbouring edges. The bench therefore holds `start` high through the whole of a frame and past its last edge. The reference model expects the frame's final edge to ignore the strobe and the edge after it, in the release cycle, to launch a new hold. It also raises `start` in the very cycle an error is reported. The model then expects `err` to stay visible for that one cycle and to drop in the cycle `busy` rises. Each output is compared with the timeline model on every clock.

// File: rtl/spe_pkg.sv
package spe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } spe_state_e;

    localparam int          FRAME_BITS  = 32;
    localparam logic [31:0] ENABLE_WORD = 32'hAC53_0000;
    localparam logic [7:0]  ECHO_VALUE  = 8'h53;
    localparam int          ECHO_SLOT   = 2;

endpackage

// File: rtl/spe_timer.sv
module spe_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/spe_shifter.sv
module spe_shifter #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_val,
    input  logic         shift,
    input  logic         sample,
    input  logic         miso,
    output logic         mosi,
    output logic [N-1:0] rx
);

    typedef struct packed {
        logic [N-1:0] tx;
        logic [N-1:0] rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.tx = load_val;
            sh_d.rx = '0;
        end else begin
            if (shift) begin
                sh_d.tx = {sh_q.tx[N-2:0], 1'b0};
            end
            if (sample) begin
                sh_d.rx = {sh_q.rx[N-2:0], miso};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign mosi = sh_q.tx[N-1];
    assign rx   = sh_q.rx;

endmodule

// File: rtl/spi_prog_entry.sv
module spi_prog_entry
    import spe_pkg::*;
#(
    parameter int SYS_CLK_HZ = 50_000_000,
    parameter int SCK_HZ     = 125_000,
    parameter int HOLD_US    = 20_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic sclk,
    output logic mosi,
    input  logic miso,
    output logic ss_n,
    output logic busy,
    output logic done,
    output logic err
);

    localparam int HALF_RAW  = SYS_CLK_HZ / (2 * SCK_HZ);
    localparam int HALF_DIV  = (HALF_RAW < 1) ? 1 : HALF_RAW;
    localparam int HOLD_RAW  = (SYS_CLK_HZ / 1000) * HOLD_US / 1000;
    localparam int HOLD_CYC  = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
    localparam int HOLD_W    = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam int PH_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W     = $clog2(FRAME_BITS);
    localparam int ECHO_LSB  = FRAME_BITS - 8 * (ECHO_SLOT + 1);

    typedef struct packed {
        spe_state_e       state;
        logic             sclk;
        logic             ss_n;
        logic [BIT_W-1:0] bitn;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  hold_ld, hold_zero;
    logic                  ph_ld, ph_zero;
    logic                  tx_ld, tx_sh, rx_smp;
    logic [FRAME_BITS-1:0] rx_w;
    logic [7:0]            echo_w;

    spe_timer #(.W(HOLD_W)) u_hold_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_ld),
        .load_val (HOLD_W'(HOLD_CYC - 1)),
        .zero     (hold_zero)
    );

    spe_timer #(.W(PH_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_ld),
        .load_val (PH_W'(HALF_DIV - 1)),
        .zero     (ph_zero)
    );

    spe_shifter #(.N(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_ld),
        .load_val (ENABLE_WORD),
        .shift    (tx_sh),
        .sample   (rx_smp),
        .miso     (miso),
        .mosi     (mosi),
        .rx       (rx_w)
    );

    assign echo_w = rx_w[ECHO_LSB +: 8];

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        hold_ld    = 1'b0;
        ph_ld      = 1'b0;
        tx_ld      = 1'b0;
        tx_sh      = 1'b0;
        rx_smp     = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state = ST_HOLD;
                    ctl_d.ss_n  = 1'b0;
                    ctl_d.err   = 1'b0;
                    hold_ld     = 1'b1;
                    tx_ld       = 1'b1;
                end
            end
            ST_HOLD: begin
                if (hold_zero) begin
                    ctl_d.state = ST_SHIFT;
                    ctl_d.bitn  = '0;
                    ph_ld       = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (ph_zero) begin
                    ph_ld = 1'b1;
                    if (!ctl_q.sclk) begin
                        ctl_d.sclk = 1'b1;
                        rx_smp     = 1'b1;
                    end else begin
                        ctl_d.sclk = 1'b0;
                        tx_sh      = 1'b1;
                        if (ctl_q.bitn == BIT_W'(FRAME_BITS - 1)) begin
                            ctl_d.state = ST_TAIL;
                        end else begin
                            ctl_d.bitn = ctl_q.bitn + 1'b1;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (ph_zero) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.ss_n  = 1'b1;
                    if (echo_w == ECHO_VALUE) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.ss_n  = 1'b1;
                ctl_d.sclk  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, sclk: 1'b0, ss_n: 1'b1,
                       bitn: '0, done: 1'b0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sclk = ctl_q.sclk;
    assign ss_n = ctl_q.ss_n;
    assign busy = (ctl_q.state != ST_IDLE);
    assign done = ctl_q.done;
    assign err  = ctl_q.err;

endmodule

// File: rtl/spe_checker.sv
module spe_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic mosi,
    input logic ss_n,
    input logic busy,
    input logic done,
    input logic err
);

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ss_n && !sclk)); // R1

    AST_SELECT_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> !sclk); // R1

    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi)); // R4

    AST_RELEASE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ss_n && (done ^ err))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_ERR_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $rose(busy)); // R8

    AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R8

    AST_BUSY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ss_n); // R11

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R11

endmodule

bind spi_prog_entry spe_checker u_spe_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .sclk  (sclk),
    .mosi  (mosi),
    .ss_n  (ss_n),
    .busy  (busy),
    .done  (done),
    .err   (err)
);

// File: tb/spi_prog_entry_bench.sv
module spi_prog_entry_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SYS_HZ     = 4_000_000;
    localparam int SCK        = 500_000;
    localparam int HOLD_US    = 20;
    localparam int H          = (SYS_HZ / 1_000_000) * HOLD_US;
    localparam int HALF       = SYS_HZ / (2 * SCK);
    localparam int T          = H + 65 * HALF;
    localparam logic [31:0] CMD = 32'hAC53_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic miso = 1'b0;
    logic sclk, mosi, ss_n, busy, done, err;

    int n_chk = 0;
    int n_fail = 0;
    int m_k = 0;
    int r_i, b_i;
    logic m_err = 1'b0, m_done = 1'b0;
    logic start_seen = 1'b0;
    logic [31:0] resp = 32'h0, m_resp = 32'h0;
    logic e_ss, e_sclk, e_mosi, e_busy, e_miso;

    spi_prog_entry #(
        .SYS_CLK_HZ (SYS_HZ),
        .SCK_HZ     (SCK),
        .HOLD_US    (HOLD_US)
    ) u_spi_prog_entry (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .sclk  (sclk),
        .mosi  (mosi),
        .miso  (miso),
        .ss_n  (ss_n),
        .busy  (busy),
        .done  (done),
        .err   (err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input string nm, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s k=%0d: got %0b expected %0b", tag, nm, m_k, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) start_seen = start;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_k = 0; m_err = 1'b0; m_done = 1'b0; miso = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_k == 0) begin
                if (start_seen) begin
                    m_k = 1; m_err = 1'b0; m_resp = resp;
                end
            end else if (m_k == T) begin
                m_k = 0;
                if (m_resp[15:8] == 8'h53) m_done = 1'b1;
                else m_err = 1'b1;
            end else begin
                m_k++;
            end
            e_miso = 1'b0;
            if (m_k == 0) begin
                e_ss = 1'b1; e_sclk = 1'b0; e_mosi = 1'b0; e_busy = 1'b0;
            end else begin
                e_ss = 1'b0; e_busy = 1'b1;
                if (m_k <= H) begin
                    e_sclk = 1'b0; e_mosi = CMD[31];
                end else begin
                    r_i = m_k - H - 1;
                    if (r_i < 64 * HALF) begin
                        b_i = r_i / (2 * HALF);
                        e_sclk = ((r_i % (2 * HALF)) >= HALF);
                        e_mosi = CMD[31 - b_i];
                        e_miso = m_resp[31 - b_i];
                    end else begin
                        e_sclk = 1'b0; e_mosi = 1'b0;
                    end
                end
            end
            chk((m_k == 0) ? "R1 R6" : "R2 R11", "ss_n", ss_n, e_ss);
            chk("R1 R2 R3", "sclk", sclk, e_sclk);
            chk("R4", "mosi", mosi, e_mosi);
            chk("R6 R9 R11", "busy", busy, e_busy);
            chk("R5 R7", "done", done, m_done);
            chk("R5 R8", "err", err, m_err);
            miso = e_miso;
        end
    end

    task automatic pulse();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        do @(negedge clk); while (!(done || err));
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "ss_n", ss_n, 1'b1);
        chk("R10", "sclk", sclk, 1'b0);
        chk("R10", "mosi", mosi, 1'b0);
        chk("R10", "busy", busy, 1'b0);
        chk("R10", "done", done, 1'b0);
        chk("R10", "err", err, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // matched echo, other bytes arbitrary
        resp = 32'hFFAC_5300; pulse(); wait_end();
        repeat (5) @(negedge clk);
        // echo off by one bit pattern: error then held
        resp = 32'h0000_5200; pulse(); wait_end();
        repeat (20) @(negedge clk);
        // R9: extra strobes during hold and during shifting
        resp = 32'h1234_5378; pulse();
        repeat (30) @(negedge clk); pulse();
        repeat (200) @(negedge clk); pulse();
        wait_end();
        repeat (3) @(negedge clk);
        // start held across the whole frame and its final edge
        resp = 32'h00AC_5300;
        @(negedge clk); start = 1'b1;
        wait_end();
        resp = 32'hFFFF_FFFF;
        @(negedge clk); start = 1'b0;
        wait_end();
        // start raised in the cycle the error is reported
        resp = 32'h0000_5300; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_end();
        repeat (4) @(negedge clk);
        resp = 32'h0000_D300; pulse(); wait_end();
        repeat (10) @(negedge clk);
        summary();
        $finish;
    end

endmodule